// File: doc/BRIEF.md
# Auxiliary ADC Successive-Approximation Sequencer

This block controls two 10-bit successive-approximation housekeeping converters, channel A and channel B. Each channel sleeps until a start request arrives. It then raises the converter's power and connects the sampled input pin. After a programmable settling delay it runs a bit-serial binary search against an external comparator. It can repeat the search for 1, 2, 4 or 8 samples and average the results. When it finishes it releases the pin, drops power and raises a done flag.

Start requests come from one of two sources. By default the main register interface issues them. When the auxiliary serial port is enabled, that port issues them instead, and the main port stays free for other settings. Channel A picks one of two input pins from a select bit, and the select value is captured when the conversion starts. Each channel also has an external-reference select bit. When that bit is set, the internal reference buffer is kept off.

The analog comparator, the capacitive DAC, the reference buffers and the serial port framing are outside this block. The comparator answers the trial code the block drives on `trial_a` / `trial_b`.

Top module: `aux_sar_seq`

## Requirements
- R1: Each sample is a 10-bit search from MSB to LSB, one bit decision per clock. A trial bit is kept when `cmp` is 1, meaning the input is at or above the trial code. With one sample, a comparator that reports `target >= trial` gives a result equal to `target`, including 0 and 1023.
- R2: After reset and while idle, `pwr` is 0. `pwr` is 1 from the clock after an accepted start until the clock on which `done` rises, when it returns to 0.
- R3: Pins are connected only while the channel is powered. For channel A, `sel_a`=1 drives `conn_a1` and `sel_a`=0 drives `conn_a2`; 0 is the default after reset. The select is captured at start, so later changes have no effect until the next conversion. `conn_b` follows channel B's power.
- R4: With `sport_en`=0, `reg_start` starts conversions and `sport_start` is ignored. With `sport_en`=1 the roles are swapped.
- R5: `avg_sel` values 0, 1, 2 and 3 select 1, 2, 4 and 8 samples. The result is the sum of the samples shifted right by `avg_sel`. `avg_sel` is captured at start.
- R6: If `settle` is S and the sample count is N, `done` rises exactly S+1+10·N clocks after the clock edge that accepted the start.
- R7: A start request for a channel that is already converting is ignored. Result and timing are unchanged.
- R8: `done` rises together with the new result and clears on the clock that accepts the next start. The result holds its value while the channel is idle.
- R9: `iref_en` for a channel is 1 only while that channel is powered and its `ext_ref` bit is 0.
- R10: The two channels convert independently and concurrently, each with its own comparator and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sport_en | input | 1 | 1: the auxiliary serial port owns the start requests |
| reg_start | input | 2 | Start pulses from the register interface, bit 0 = A, bit 1 = B |
| sport_start | input | 2 | Start pulses from the auxiliary serial port |
| sel_a | input | 1 | Channel A input pick: 1 = first pin, 0 = second pin |
| ext_ref | input | 2 | Per-channel external reference select |
| avg_sel | input | 2 | log2 of the sample count |
| settle | input | 8 | Settling clocks after power-up |
| cmp | input | 2 | Comparator outputs, 1 = input at or above trial |
| pwr | output | 2 | Converter power enables |
| conn_a1 | output | 1 | Channel A first input pin connected |
| conn_a2 | output | 1 | Channel A second input pin connected |
| conn_b | output | 1 | Channel B input pin connected |
| iref_en | output | 2 | Internal reference buffer enables |
| trial_a | output | 10 | Channel A trial code to the DAC |
| trial_b | output | 10 | Channel B trial code to the DAC |
| result_a | output | 10 | Channel A averaged result |
| result_b | output | 10 | Channel B averaged result |
| done | output | 2 | Per-channel conversion complete |

## Verification
A wrong bit index or a wrong keep/clear decision shows up as a wrong result on the first completed conversion, 10 clocks after the settle delay. A miscounted settle or sample counter moves the rising edge of `done` by at least one clock, and the bench detects that by checking `done` one clock before and on the exact expected edge. A wrong sample tally or averaging shift shows up only when the samples vary, so the bench gives each averaged sample a different target and expects a truncated mean. State that leaks between a busy channel and new requests is caught by re-pulsing start during a conversion and by running both channels together.

// File: rtl/aux_sar_pkg.sv
package aux_sar_pkg;

    parameter int RES_W     = 10;
    parameter int NUM_CH    = 2;
    parameter int AVG_SEL_W = 2;
    parameter int SETTLE_W  = 8;
    parameter int MAX_LOG   = (1 << AVG_SEL_W) - 1;
    parameter int ACC_W     = RES_W + MAX_LOG;
    parameter int BIT_IDX_W = $clog2(RES_W);
    parameter int SMP_W     = (MAX_LOG > 0) ? MAX_LOG : 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_BIT    = 2'd2
    } sar_state_e;

    typedef logic [RES_W-1:0] code_t;

    typedef struct packed {
        logic [AVG_SEL_W-1:0] avg_sel;
        logic [SETTLE_W-1:0]  settle;
    } chan_cfg_t;

    function automatic code_t bit_mask(input logic [BIT_IDX_W-1:0] idx);
        return code_t'(1) << idx;
    endfunction

    function automatic logic [SMP_W-1:0] last_sample(input logic [AVG_SEL_W-1:0] a);
        int n;
        n = (1 << a) - 1;
        return SMP_W'(n);
    endfunction

endpackage

// File: rtl/aux_sar_src.sv
module aux_sar_src
    import aux_sar_pkg::*;
(
    input  logic              sport_en,
    input  logic [NUM_CH-1:0] reg_start,
    input  logic [NUM_CH-1:0] sport_start,
    output logic [NUM_CH-1:0] start
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_src
        assign start[i] = sport_en ? sport_start[i] : reg_start[i];
    end
endmodule

// File: rtl/aux_sar_chan.sv
module aux_sar_chan
    import aux_sar_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  chan_cfg_t cfg,
    input  logic      cmp,
    output logic      busy,
    output code_t     trial,
    output code_t     result,
    output logic      done
);
    sar_state_e                 st;
    logic [SETTLE_W-1:0]        cnt;
    logic [BIT_IDX_W-1:0]       bit_idx;
    code_t                      code;
    code_t                      kept;
    code_t                      next_code;
    logic [ACC_W-1:0]           acc;
    logic [ACC_W-1:0]           acc_sum;
    logic [SMP_W-1:0]           smp;
    logic [AVG_SEL_W-1:0]       avg_q;

    // decision on the current trial bit, then arm the next lower one
    always_comb begin
        kept      = cmp ? code : (code & ~bit_mask(bit_idx));
        next_code = kept;
        if (bit_idx != '0)
            next_code = kept | bit_mask(bit_idx - 1'b1);
        acc_sum   = acc + ACC_W'(kept);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            code    <= '0;
            acc     <= '0;
            smp     <= '0;
            avg_q   <= '0;
            result  <= '0;
            done    <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st    <= ST_SETTLE;
                        cnt   <= cfg.settle;
                        avg_q <= cfg.avg_sel;
                        acc   <= '0;
                        smp   <= '0;
                        done  <= 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == '0) begin
                        st      <= ST_BIT;
                        code    <= bit_mask(BIT_IDX_W'(RES_W - 1));
                        bit_idx <= BIT_IDX_W'(RES_W - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_BIT: begin
                    if (bit_idx == '0) begin
                        if (smp == last_sample(avg_q)) begin
                            result <= code_t'(acc_sum >> avg_q);
                            done   <= 1'b1;
                            code   <= '0;
                            st     <= ST_IDLE;
                        end else begin
                            smp     <= smp + 1'b1;
                            acc     <= acc_sum;
                            code    <= bit_mask(BIT_IDX_W'(RES_W - 1));
                            bit_idx <= BIT_IDX_W'(RES_W - 1);
                        end
                    end else begin
                        code    <= next_code;
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (st != ST_IDLE);
    assign trial = code;
endmodule

// File: rtl/aux_sar_seq.sv
module aux_sar_seq
    import aux_sar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sport_en,
    input  logic [NUM_CH-1:0]    reg_start,
    input  logic [NUM_CH-1:0]    sport_start,
    input  logic                 sel_a,
    input  logic [NUM_CH-1:0]    ext_ref,
    input  logic [AVG_SEL_W-1:0] avg_sel,
    input  logic [SETTLE_W-1:0]  settle,
    input  logic [NUM_CH-1:0]    cmp,
    output logic [NUM_CH-1:0]    pwr,
    output logic                 conn_a1,
    output logic                 conn_a2,
    output logic                 conn_b,
    output logic [NUM_CH-1:0]    iref_en,
    output logic [RES_W-1:0]     trial_a,
    output logic [RES_W-1:0]     trial_b,
    output logic [RES_W-1:0]     result_a,
    output logic [RES_W-1:0]     result_b,
    output logic [NUM_CH-1:0]    done
);
    logic [NUM_CH-1:0] start;
    code_t             trial_v  [NUM_CH];
    code_t             result_v [NUM_CH];
    chan_cfg_t         cfg;
    logic              sel_q;

    assign cfg.avg_sel = avg_sel;
    assign cfg.settle  = settle;

    aux_sar_src u_src (
        .sport_en    (sport_en),
        .reg_start   (reg_start),
        .sport_start (sport_start),
        .start       (start)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        aux_sar_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .start  (start[i]),
            .cfg    (cfg),
            .cmp    (cmp[i]),
            .busy   (pwr[i]),
            .trial  (trial_v[i]),
            .result (result_v[i]),
            .done   (done[i])
        );
        assign iref_en[i] = pwr[i] & ~ext_ref[i];
    end

    // channel A pin pick is frozen when its conversion is accepted
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else if (start[0] && !pwr[0])
            sel_q <= sel_a;
    end

    assign conn_a1  = pwr[0] &  sel_q;
    assign conn_a2  = pwr[0] & ~sel_q;
    assign conn_b   = pwr[1];
    assign trial_a  = trial_v[0];
    assign trial_b  = trial_v[1];
    assign result_a = result_v[0];
    assign result_b = result_v[1];
endmodule

// File: rtl/aux_sar_chk.sv
module aux_sar_chk
    import aux_sar_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_CH-1:0]    pwr,
    input logic                 conn_a1,
    input logic                 conn_a2,
    input logic                 conn_b,
    input logic [NUM_CH-1:0]    ext_ref,
    input logic [NUM_CH-1:0]    iref_en,
    input logic [RES_W-1:0]     trial_a,
    input logic [RES_W-1:0]     trial_b,
    input logic [RES_W-1:0]     result_a,
    input logic [RES_W-1:0]     result_b,
    input logic [NUM_CH-1:0]    done
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r3_conn_a_powered: assert property (@(posedge clk) disable iff (rst)
        (conn_a1 || conn_a2) |-> pwr[0]);
    a_r3_conn_b_powered: assert property (@(posedge clk) disable iff (rst)
        conn_b |-> pwr[1]);
    a_r3_one_pin: assert property (@(posedge clk) disable iff (rst)
        $onehot0({conn_a1, conn_a2}));
    a_r8_done_clears_a: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr[0]) |-> !done[0]);
    a_r8_done_clears_b: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr[1]) |-> !done[1]);
    a_r2_power_drop_a: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr[0]) |-> done[0]);
    a_r2_power_drop_b: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr[1]) |-> done[1]);
    a_r8_hold_a: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !pwr[0] && $past(!pwr[0])) |-> $stable(result_a));
    a_r8_hold_b: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !pwr[1] && $past(!pwr[1])) |-> $stable(result_b));
    a_r9_ext_blocks: assert property (@(posedge clk) disable iff (rst)
        (ext_ref & iref_en) == '0);
    a_r1_idle_trial: assert property (@(posedge clk) disable iff (rst)
        (!pwr[0] |-> trial_a == '0) and (!pwr[1] |-> trial_b == '0));
endmodule

bind aux_sar_seq aux_sar_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr      (pwr),
    .conn_a1  (conn_a1),
    .conn_a2  (conn_a2),
    .conn_b   (conn_b),
    .ext_ref  (ext_ref),
    .iref_en  (iref_en),
    .trial_a  (trial_a),
    .trial_b  (trial_b),
    .result_a (result_a),
    .result_b (result_b),
    .done     (done)
);

// File: tb/aux_sar_seq_bench.sv
`timescale 1ns/1ps
module aux_sar_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sport_en = 1'b0;
    logic [1:0] reg_start = '0;
    logic [1:0] sport_start = '0;
    logic       sel_a = 1'b0;
    logic [1:0] ext_ref = '0;
    logic [1:0] avg_sel = '0;
    logic [7:0] settle = '0;
    logic [1:0] cmp;
    logic [1:0] pwr, iref_en, done;
    logic       conn_a1, conn_a2, conn_b;
    logic [9:0] trial_a, trial_b, result_a, result_b;
    logic [9:0] tgt0 = '0, tgt1 = '0;
    int         tv [8];
    int         total = 0, bad = 0;

    always #10 clk = ~clk;

    assign cmp[0] = (tgt0 >= trial_a);
    assign cmp[1] = (tgt1 >= trial_b);

    aux_sar_seq u_aux_sar_seq (
        .clk(clk), .rst(rst), .sport_en(sport_en), .reg_start(reg_start),
        .sport_start(sport_start), .sel_a(sel_a), .ext_ref(ext_ref),
        .avg_sel(avg_sel), .settle(settle), .cmp(cmp), .pwr(pwr),
        .conn_a1(conn_a1), .conn_a2(conn_a2), .conn_b(conn_b),
        .iref_en(iref_en), .trial_a(trial_a), .trial_b(trial_b),
        .result_a(result_a), .result_b(result_b), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int res_of(input int ch);
        return (ch == 0) ? int'(result_a) : int'(result_b);
    endfunction

    task automatic set_tgt(input int ch, input int v);
        if (ch == 0) tgt0 = 10'(v); else tgt1 = 10'(v);
    endtask

    task automatic drive_start(input int ch, input bit v);
        if (sport_en) sport_start[ch] = v; else reg_start[ch] = v;
    endtask

    // one full conversion on channel ch using tv[0..2^avg-1] as sample targets
    task automatic run_conv(input int ch, input int avg, input int st,
                            input string req, input bit poke_busy);
        int n = 1 << avg;
        int sum = 0;
        @(negedge clk);
        avg_sel = 2'(avg);
        settle  = 8'(st);
        drive_start(ch, 1'b1);
        @(posedge clk);
        @(negedge clk);
        drive_start(ch, 1'b0);
        chk(pwr[ch] == 1'b1, "R2 power up", int'(pwr[ch]), 1);
        chk(done[ch] == 1'b0, "R8 done cleared", int'(done[ch]), 0);
        repeat (st + 1) @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            set_tgt(ch, tv[k]);
            sum += tv[k];
            if (poke_busy && k == 0) drive_start(ch, 1'b1);
            @(posedge clk);
            @(negedge clk);
            drive_start(ch, 1'b0);
            repeat (8) @(posedge clk);
            @(negedge clk);
            if (k == n - 1)
                chk(done[ch] == 1'b0, "R6 done not early", int'(done[ch]), 0);
            @(posedge clk);
        end
        @(negedge clk);
        chk(done[ch] == 1'b1, "R6 done on time", int'(done[ch]), 1);
        chk(res_of(ch) == (sum >> avg), req, res_of(ch), sum >> avg);
        chk(pwr[ch] == 1'b0, "R2 power down", int'(pwr[ch]), 0);
    endtask

    task automatic t_reset();
        chk(pwr == 2'b00, "R2 reset power", int'(pwr), 0);
        chk(done == 2'b00, "R8 reset done", int'(done), 0);
        chk({conn_a1, conn_a2, conn_b} == 3'b000, "R3 reset pins",
            int'({conn_a1, conn_a2, conn_b}), 0);
        chk(result_a == 10'd0, "R8 reset result", int'(result_a), 0);
    endtask

    task automatic t_sar_codes();
        int codes [5] = '{0, 1023, 513, 341, 682};
        foreach (codes[i]) begin
            tv[0] = codes[i];
            run_conv(0, 0, 2, "R1 single sample code", 1'b0);
        end
        tv[0] = 777;
        run_conv(1, 0, 1, "R1 R10 channel B code", 1'b0);
    endtask

    task automatic t_average();
        tv = '{100, 101, 103, 110, 90, 95, 99, 120};
        run_conv(0, 1, 0, "R5 average of 2", 1'b0);
        run_conv(0, 2, 0, "R5 average of 4", 1'b0);
        run_conv(1, 3, 0, "R5 average of 8", 1'b0);
        tv = '{1023, 1023, 1023, 1023, 1023, 1023, 1023, 1023};
        run_conv(0, 3, 1, "R5 full scale sum of 8", 1'b0);
    endtask

    task automatic t_settle();
        tv[0] = 300;
        run_conv(0, 0, 0, "R6 settle zero", 1'b0);
        run_conv(0, 0, 7, "R6 settle seven", 1'b0);
        chk(result_a == 10'd300, "R8 result held while idle", int'(result_a), 300);
    endtask

    task automatic t_source();
        sport_en = 1'b0;
        @(negedge clk); sport_start[0] = 1'b1;
        @(posedge clk); @(negedge clk); sport_start[0] = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(pwr[0] == 1'b0, "R4 serial start ignored", int'(pwr[0]), 0);
        sport_en = 1'b1;
        @(negedge clk); reg_start[0] = 1'b1;
        @(posedge clk); @(negedge clk); reg_start[0] = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(pwr[0] == 1'b0, "R4 register start ignored", int'(pwr[0]), 0);
        tv[0] = 444;
        run_conv(0, 0, 1, "R4 serial port conversion", 1'b0);
        sport_en = 1'b0;
    endtask

    task automatic t_busy();
        tv = '{200, 210, 0, 0, 0, 0, 0, 0};
        run_conv(0, 1, 3, "R7 restart while busy ignored", 1'b1);
    endtask

    task automatic t_mux();
        sel_a = 1'b1;
        settle = 8'd2; avg_sel = 2'd0; tgt0 = 10'd50;
        @(negedge clk); reg_start[0] = 1'b1;
        @(posedge clk); @(negedge clk); reg_start[0] = 1'b0;
        chk(conn_a1 == 1'b1 && conn_a2 == 1'b0, "R3 first pin", int'({conn_a1, conn_a2}), 2);
        sel_a = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(conn_a1 == 1'b1 && conn_a2 == 1'b0, "R3 select frozen", int'({conn_a1, conn_a2}), 2);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(done[0] && !conn_a1 && !conn_a2, "R3 pins released",
            int'({done[0], conn_a1, conn_a2}), 4);
        @(negedge clk); reg_start[0] = 1'b1;
        @(posedge clk); @(negedge clk); reg_start[0] = 1'b0;
        chk(conn_a2 == 1'b1 && conn_a1 == 1'b0, "R3 second pin", int'({conn_a1, conn_a2}), 1);
        repeat (13) @(posedge clk);
        @(negedge clk);
        chk(result_a == 10'd50, "R3 conversion via second pin", int'(result_a), 50);
    endtask

    task automatic t_ref_dual();
        ext_ref = 2'b01; settle = 8'd1; avg_sel = 2'd0;
        tgt0 = 10'd123; tgt1 = 10'd900;
        @(negedge clk); reg_start = 2'b11;
        @(posedge clk); @(negedge clk); reg_start = 2'b00;
        chk(iref_en == 2'b10, "R9 reference enables", int'(iref_en), 2);
        chk(conn_b == 1'b1, "R3 channel B pin", int'(conn_b), 1);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(done == 2'b11, "R10 both done", int'(done), 3);
        chk(result_a == 10'd123, "R10 channel A result", int'(result_a), 123);
        chk(result_b == 10'd900, "R10 channel B result", int'(result_b), 900);
        chk(iref_en == 2'b00, "R9 reference off when idle", int'(iref_en), 0);
        ext_ref = 2'b00;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sar_codes();
        t_average();
        t_settle();
        t_source();
        t_busy();
        t_mux();
        t_ref_dual();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule